// File: doc/BRIEF.md
# Rate-Smoothing Elastic Store

This block turns a bursty byte stream coming from a framed line-side path into a steady serial bit stream. The line side writes payload bytes in runs. Once per superframe a whole frame slot carries no payload, and the writer marks that slot with a non-payload qualifier. Bytes are held in a circular store. A serializer then sends them out one bit per cycle of a serial clock that the block makes itself.

The serial clock comes from a modulo phase accumulator. On every system clock the accumulator is advanced by a rate word. The rate word is captured only while reset is held, so the output rate stays fixed for the whole time the block runs. The rate resolution is the system clock divided by the accumulator modulus. For example, a 176.64 MHz system clock with a modulus of 1,024,000 gives 172.5 Hz per step of the rate word. That covers serial rates from 8 kb/s up to 12.288 Mb/s. The output carries only the clock and the data, with no framing.

When the average input and output rates match, the store absorbs the periodic empty slot and small jitter. When they do not match, it reports overflow or underflow through flags that stay set until the next reset.

Top module: `rate_smoother`

## Requirements
- R1: While reset is held, `ser_data` and `ser_clk` are 1 and both `ovf_flag` and `unf_flag` are 0.
- R2: The accumulator starts at 0 and adds `rate_word` modulo `MODULUS` on every system clock. `ser_clk` is 1 exactly while the accumulator is below `MODULUS/2`. Each wrap of the accumulator makes exactly one rising edge of `ser_clk`, so the edge count after N cycles is floor(N*rate/MODULUS). This holds for rate words from 1 to `MODULUS/2`.
- R3: `rate_word` is sampled only while `rst_n` is low. Changing it after reset is released does not change the `ser_clk` rate.
- R4: `ser_data` changes only in the cycle where `ser_clk` rises, and each rise presents one new bit. Bytes go out most significant bit first and stay aligned to 8-bit boundaries counted from the first rise after reset.
- R5: A byte is stored when `wr_valid` is 1 and `idle_slot` is 0. A byte presented with `idle_slot` = 1 is never stored and never appears on `ser_data`.
- R6: Until the store has held at least `DEPTH/2` bytes at some point since reset, every byte sent is the idle byte 0xFF, and `unf_flag` stays 0.
- R7: After readout has started, if the store is empty at a byte boundary, the byte 0xFF is sent and `unf_flag` is set. Readout picks up stored bytes again at the next boundary where one is available.
- R8: A byte written while the store holds `DEPTH` bytes, with no byte leaving in the same cycle, is dropped and sets `ovf_flag`. The bytes already stored still come out in order.
- R9: Both flags are sticky, and only reset clears them.
- R10: A gapped input has one empty slot in every four and an average byte rate equal to the serial byte rate. With such input, every payload byte comes out in write order, and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; rate word captured while low |
| rate_word | input | $clog2(MODULUS) | Phase step added per system clock |
| wr_valid | input | 1 | Byte strobe from the line side |
| wr_byte | input | 8 | Byte presented with the strobe |
| idle_slot | input | 1 | Marks the current slot as carrying no payload |
| ser_clk | output | 1 | Generated serial clock |
| ser_data | output | 1 | Serial data, updated on the serial clock rising edge |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |

## Verification
A sweep of rate words counts serial clock edges and compares the count with the accumulator arithmetic. A second run changes the rate word after reset to show that the captured rate holds. The data path is tried with four input patterns:
- a short fill that stops below the half-full start level, which separates waiting from underflow;
- a gapped superframe stream at a matched average rate, with junk bytes placed in the non-payload slots, which shows that marked bytes are discarded and that order is kept;
- a drain after the stream ends, which shows idle fill and the underflow flag;
- a back-to-back burst against a slow output, which shows that surplus bytes are dropped and that the stored prefix survives.

// File: rtl/es_pkg.sv
package es_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] shift;
        logic [2:0]        left;
        logic              bit_out;
        logic              started;
        logic              underflow;
    } ser_state_t;
endpackage

// File: rtl/es_nco.sv
module es_nco #(
    parameter int MODULUS = 1024000,
    localparam int RW = $clog2(MODULUS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rate_in,
    output logic          ser_clk_o,
    output logic          tick_o
);
    localparam logic [RW:0]   MOD_V  = (RW+1)'(MODULUS);
    localparam logic [RW-1:0] HALF_V = RW'(MODULUS / 2);

    typedef struct packed {
        logic [RW-1:0] acc;
        logic [RW-1:0] rate;
    } nco_t;

    nco_t        nco_q, nco_d;
    logic [RW:0] sum;
    logic        wrap;

    always_comb begin
        nco_d = nco_q;
        sum   = {1'b0, nco_q.acc} + {1'b0, nco_q.rate};
        wrap  = (sum >= MOD_V);
        if (wrap) begin
            nco_d.acc = RW'(sum - MOD_V);
        end else begin
            nco_d.acc = sum[RW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nco_q.acc  <= '0;
            nco_q.rate <= rate_in;
        end else begin
            nco_q <= nco_d;
        end
    end

    assign ser_clk_o = (nco_q.acc < HALF_V);
    assign tick_o    = wrap;
endmodule

// File: rtl/es_fifo.sv
module es_fifo
    import es_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              pop,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CW-1:0]     fill,
    output logic              ovf
);
    localparam logic [AW-1:0] LAST_V = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_t;

    fifo_t             fifo_q, fifo_d;
    logic              accept;
    logic [BYTE_W-1:0] store [DEPTH];

    always_comb begin
        fifo_d = fifo_q;
        accept = wr_en && ((fifo_q.cnt != FULL_V) || pop);
        if (wr_en && !accept) begin
            fifo_d.ovf = 1'b1;
        end
        if (accept) begin
            fifo_d.wp = (fifo_q.wp == LAST_V) ? '0 : fifo_q.wp + 1'b1;
        end
        if (pop) begin
            fifo_d.rp = (fifo_q.rp == LAST_V) ? '0 : fifo_q.rp + 1'b1;
        end
        fifo_d.cnt = fifo_q.cnt + CW'(accept) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            store[fifo_q.wp] <= wr_byte;
        end
    end

    assign rd_byte = store[fifo_q.rp];
    assign fill    = fifo_q.cnt;
    assign ovf     = fifo_q.ovf;
endmodule

// File: rtl/es_serializer.sv
module es_serializer
    import es_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CW-1:0]     fill,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              pop,
    output logic              ser_data,
    output logic              unf
);
    localparam logic [CW-1:0] START_V = CW'(DEPTH / 2);

    ser_state_t        ser_q, ser_d;
    logic [BYTE_W-1:0] next_byte;

    always_comb begin
        ser_d     = ser_q;
        pop       = 1'b0;
        next_byte = IDLE_BYTE;
        if (fill >= START_V) begin
            ser_d.started = 1'b1;
        end
        if (tick) begin
            if (ser_q.left == 3'd0) begin
                if (ser_q.started && (fill != '0)) begin
                    next_byte = rd_byte;
                    pop       = 1'b1;
                end else if (ser_q.started) begin
                    ser_d.underflow = 1'b1;
                end
                ser_d.bit_out = next_byte[BYTE_W-1];
                ser_d.shift   = {next_byte[BYTE_W-2:0], 1'b0};
                ser_d.left    = 3'd7;
            end else begin
                ser_d.bit_out = ser_q.shift[BYTE_W-1];
                ser_d.shift   = {ser_q.shift[BYTE_W-2:0], 1'b0};
                ser_d.left    = ser_q.left - 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q         <= '0;
            ser_q.bit_out <= 1'b1;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign ser_data = ser_q.bit_out;
    assign unf      = ser_q.underflow;
endmodule

// File: rtl/rate_smoother.sv
module rate_smoother
    import es_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int MODULUS = 1024000,
    localparam int RW = $clog2(MODULUS),
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RW-1:0]     rate_word,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              idle_slot,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ovf_flag,
    output logic              unf_flag
);
    logic              tick;
    logic              pop;
    logic              wr_en;
    logic [CW-1:0]     fill;
    logic [BYTE_W-1:0] rd_byte;

    assign wr_en = wr_valid && !idle_slot;

    es_nco #(.MODULUS(MODULUS)) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_in   (rate_word),
        .ser_clk_o (ser_clk),
        .tick_o    (tick)
    );

    es_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .pop     (pop),
        .rd_byte (rd_byte),
        .fill    (fill),
        .ovf     (ovf_flag)
    );

    es_serializer #(.DEPTH(DEPTH)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .fill     (fill),
        .rd_byte  (rd_byte),
        .pop      (pop),
        .ser_data (ser_data),
        .unf      (unf_flag)
    );
endmodule

// File: rtl/rate_smoother_chk.sv
module rate_smoother_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_clk,
    input logic          ser_data,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic [CW-1:0] fill,
    input logic          pop
);
    assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> $rose(ser_clk));

    assert_fill_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    assert_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(fill) == CW'(DEPTH)));

    assert_idle_on_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> ser_data);
endmodule

bind rate_smoother rate_smoother_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag),
    .fill     (fill),
    .pop      (pop)
);

// File: tb/tb_rate_smoother.sv
`timescale 1ns/1ps
module tb_rate_smoother;
    localparam int DEPTH   = 16;
    localparam int MODULUS = 16;
    localparam int RW      = $clog2(MODULUS);
    localparam int CAPN    = 8192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] rate_word = '0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_byte = '0;
    logic          idle_slot = 1'b0;
    logic          ser_clk, ser_data, ovf_flag, unf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic cap [CAPN];
    int   cap_n = 0;
    logic prev_clk = 1'b1;

    always #2.5 clk = ~clk;

    rate_smoother #(.DEPTH(DEPTH), .MODULUS(MODULUS)) dut (
        .clk(clk), .rst_n(rst_n), .rate_word(rate_word),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .idle_slot(idle_slot),
        .ser_clk(ser_clk), .ser_data(ser_data),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            cap_n    = 0;
            prev_clk = 1'b1;
        end else begin
            if (ser_clk && !prev_clk && cap_n < CAPN) begin
                cap[cap_n] = ser_data;
                cap_n++;
            end
            prev_clk = ser_clk;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pv(input int i);
        return 8'((i * 29 + 3) & 255);
    endfunction

    function automatic logic [7:0] cap_byte(input int i);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) r = {r[6:0], cap[8*i+b]};
        return r;
    endfunction

    function automatic int first_data();
        for (int i = 0; i < cap_n / 8; i++) begin
            if (cap_byte(i) != 8'hFF) return i;
        end
        return -1;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input int rate);
        @(negedge clk);
        rst_n     = 1'b0;
        rate_word = RW'(rate);
        wr_valid  = 1'b0;
        idle_slot = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic id);
        wr_valid  = 1'b1;
        wr_byte   = b;
        idle_slot = id;
        @(negedge clk);
        wr_valid  = 1'b0;
        idle_slot = 1'b0;
    endtask

    initial begin
        int k;
        int j;
        int n;
        // R1: reset state
        rst_n = 1'b0;
        rate_word = RW'(4);
        repeat (4) @(negedge clk);
        #1;
        chk(ser_data == 1'b1, "R1 ser_data in reset", int'(ser_data), 1);
        chk(ser_clk == 1'b1, "R1 ser_clk in reset", int'(ser_clk), 1);
        chk(ovf_flag == 1'b0, "R1 ovf in reset", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R1 unf in reset", int'(unf_flag), 0);

        // R2: edge count sweep; R6: idle ones and no underflow before start
        for (int r = 1; r <= MODULUS / 2; r++) begin
            do_reset(r);
            wait_cyc(640);
            chk((cap_n >= 40 * r - 1) && (cap_n <= 40 * r + 1), "R2 edge count", cap_n, 40 * r);
            chk(first_data() == -1, "R6 only idle bytes without data", first_data(), -1);
            chk(unf_flag == 1'b0, "R6 no underflow before start", int'(unf_flag), 0);
        end

        // R3: rate word ignored after reset release
        do_reset(2);
        rate_word = RW'(8);
        wait_cyc(640);
        chk((cap_n >= 79) && (cap_n <= 81), "R3 rate locked", cap_n, 80);

        // R6/R7: below start level, then start, drain and underflow
        do_reset(4);
        for (int i = 0; i < 7; i++) begin
            put_byte(pv(i), 1'b0);
            wait_cyc(23);
        end
        wait_cyc(400);
        chk(first_data() == -1, "R6 held below half full", first_data(), -1);
        chk(unf_flag == 1'b0, "R6 no underflow while waiting", int'(unf_flag), 0);
        put_byte(pv(7), 1'b0);
        wait_cyc(700);
        k = first_data();
        chk(k >= 0, "R6 readout started", k, 0);
        for (int i = 0; i < 8; i++) begin
            chk((k >= 0) && (cap_byte(k + i) == pv(i)), "R4 byte order after start",
                (k >= 0) ? int'(cap_byte(k + i)) : -1, int'(pv(i)));
        end
        chk((k >= 0) && (cap_n / 8 > k + 8) && (cap_byte(k + 8) == 8'hFF), "R7 idle byte on empty",
            (k >= 0) ? int'(cap_byte(k + 8)) : -1, 255);
        chk(unf_flag == 1'b1, "R7 underflow flag", int'(unf_flag), 1);

        // R5/R10: gapped superframes at matched average rate
        do_reset(4);
        n = 0;
        for (int sf = 0; sf < 3; sf++) begin
            for (int fr = 0; fr < 4; fr++) begin
                for (int sl = 0; sl < 4; sl++) begin
                    if (fr == 3) begin
                        put_byte(8'h5A, 1'b1);
                    end else begin
                        put_byte(pv(n), 1'b0);
                        n++;
                    end
                    wait_cyc(23);
                end
            end
        end
        chk(ovf_flag == 1'b0, "R10 no overflow on gapped stream", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R10 no underflow on gapped stream", int'(unf_flag), 0);
        wait_cyc(800);
        k = first_data();
        j = 0;
        while ((k >= 0) && (j < n) && (k + j < cap_n / 8) && (cap_byte(k + j) == pv(j))) j++;
        chk(j == n, "R5 R10 payload bytes in order, idle slots skipped", j, n);
        chk((k >= 0) && (cap_n / 8 > k + n) && (cap_byte(k + n) == 8'hFF), "R7 idle after drain",
            (k >= 0) ? int'(cap_byte(k + n)) : -1, 255);
        chk(unf_flag == 1'b1, "R7 underflow after drain", int'(unf_flag), 1);

        // R8/R9: burst into a slow output
        do_reset(1);
        for (int i = 0; i < 24; i++) begin
            wr_valid = 1'b1;
            wr_byte  = pv(i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        #1;
        chk(ovf_flag == 1'b1, "R8 overflow flag", int'(ovf_flag), 1);
        wait_cyc(2600);
        k = first_data();
        j = 0;
        while ((k >= 0) && (j < 24) && (k + j < cap_n / 8) && (cap_byte(k + j) == pv(j))) j++;
        chk((j >= 16) && (j <= 18), "R8 stored prefix kept", j, 17);
        chk((k >= 0) && (cap_n / 8 > k + j) && (cap_byte(k + j) == 8'hFF), "R8 dropped bytes absent",
            (k >= 0) ? int'(cap_byte(k + j)) : -1, 255);
        chk(ovf_flag == 1'b1, "R9 overflow still set", int'(ovf_flag), 1);
        chk(unf_flag == 1'b1, "R9 underflow set after drain", int'(unf_flag), 1);
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        chk(ovf_flag == 1'b0, "R9 reset clears overflow", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R9 reset clears underflow", int'(unf_flag), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule